// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Array

This block is a small, fully associative cache of address translations in which every entry carries an address-space identifier beside its virtual page number and physical page number. A lookup compares the presented page number and the current identifier against every entry in parallel. It returns hit and physical page in the same cycle. A translation therefore only matches for the address space that installed it. The same virtual page can be held at once for several address spaces, each with its own physical page.

On a miss, the block starts a single page-walk request and records the missing page number. When the walker answers, the block writes a new entry into a victim slot. The entry takes the recorded page number, the identifier current at that moment and the returned physical page. A fence pulse empties the whole array, whatever identifiers the entries hold. A change of the current identifier abandons the walk in flight, so that a late answer never lands in the array under the wrong space.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, no lookup hits, and no walk is outstanding.
- R2: A lookup hits only when some valid entry holds both `lkVpn` and `curAsid`. `lkHit` and `lkPpn` are valid in the same cycle as `lkValid`, and `lkPpn` is zero when there is no hit.
- R3: A one-cycle `fence` invalidates every entry, whatever its identifier. A walk answer that arrives in the fence cycle is discarded but still ends the walk, and the victim pointer returns to entry 0.
- R4: The same page number installed under two identifiers gives two entries, and each identifier reads back its own physical page.
- R5: A lookup that misses raises `walkReqValid` in the same cycle with `walkReqVpn` equal to `lkVpn`, provided no walk is outstanding and `curAsid` equals its value of the previous cycle. A hit never raises it.
- R6: At most one walk is outstanding, and no further `walkReqValid` is raised while it is. `walkRespValid` during an outstanding walk writes an entry from the recorded page number, `curAsid` and `walkRespPpn`, and that entry is visible from the next cycle. `walkRespValid` with no walk outstanding is ignored.
- R7: When `curAsid` differs from its value in the previous cycle, any outstanding walk is cancelled. Its answer, whether in that cycle or later, writes nothing.
- R8: The victim is the first invalid entry at or after the round-robin pointer, searching upward with wrap. If no entry is invalid, the victim is the entry at the pointer. After each write the pointer moves to victim+1, modulo ENTRIES, which must be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curAsid | input | ASID_W | Current address-space identifier |
| fence | input | 1 | Invalidate all entries |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkHit | output | 1 | Lookup hit |
| lkPpn | output | PPN_W | Physical page on hit, else zero |
| walkReqValid | output | 1 | Start a page walk |
| walkReqVpn | output | VPN_W | Page number to walk |
| walkRespValid | input | 1 | Walk answer present |
| walkRespPpn | input | PPN_W | Physical page from the walk |

## Verification
The hardest case to reach is the race between an identifier change and a walk answer, both at the same edge and one cycle after it. A cancelled walk leaves no trace at the ports except that a lookup afterwards misses again and is allowed to start a fresh walk. The bench starts a walk, switches the identifier either one cycle before the answer or in the same cycle as it, and then switches back. It then looks up the page again and expects a miss together with a new walk request, which shows that nothing was written and that the walk slot is free. Eviction order is reached by fencing, filling every slot, and then forcing further misses whose refills displace the oldest entries in turn.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic fill;      // write a new entry this cycle
    logic flushAll;  // invalidate the whole array
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              fence,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic              lkHit,
  input  logic              walkRespValid,
  output logic              walkReqValid,
  output logic [VPN_W-1:0]  walkReqVpn,
  output logic [VPN_W-1:0]  fillVpn,
  output logic              walkBusy,
  output tlbStrobe_t        strb
);
  logic [ASID_W-1:0] asidQ;
  logic [VPN_W-1:0]  pendVpn;
  logic              busy;
  logic              asidChg;

  assign asidChg      = (curAsid != asidQ);
  assign walkReqValid = lkValid && !lkHit && !busy && !asidChg;
  assign walkReqVpn   = lkVpn;
  assign fillVpn      = pendVpn;
  assign walkBusy     = busy;

  always_comb begin
    strb          = '0;
    strb.flushAll = fence;
    strb.fill     = walkRespValid && busy && !asidChg && !fence;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asidQ   <= curAsid;
      busy    <= 1'b0;
      pendVpn <= '0;
    end else begin
      asidQ <= curAsid;
      if (asidChg) begin
        busy <= 1'b0;
      end else if (busy && walkRespValid) begin
        busy <= 1'b0;
      end else if (walkReqValid) begin
        busy    <= 1'b1;
        pendVpn <= lkVpn;
      end
    end
  end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strb,
  input  logic [ASID_W-1:0]  curAsid,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  output logic [ENTRIES-1:0] hitVec,
  output logic               lkHit,
  output logic [PPN_W-1:0]   lkPpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   vpnA  [ENTRIES];
  logic [ASID_W-1:0]  asidA [ENTRIES];
  logic [PPN_W-1:0]   ppnA  [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   cand;
  logic               found;
  logic [PPN_W-1:0]   ppnOr;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hitVec[i] = lkValid && valid[i] && (vpnA[i] == lkVpn) && (asidA[i] == curAsid);
  end

  always_comb begin
    ppnOr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) ppnOr = ppnOr | ppnA[i];
    end
  end

  assign lkHit = |hitVec;
  assign lkPpn = ppnOr;

  // round-robin: first invalid slot from the pointer, else the pointer
  always_comb begin
    victim = rrPtr;
    found  = 1'b0;
    cand   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      cand = rrPtr + IDX_W'(k);
      if (!found && !valid[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      rrPtr <= '0;
    end else if (strb.flushAll) begin
      valid <= '0;
      rrPtr <= '0;
    end else if (strb.fill) begin
      valid[victim] <= 1'b1;
      rrPtr         <= victim + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill && !strb.flushAll) begin
      vpnA[victim]  <= fillVpn;
      asidA[victim] <= curAsid;
      ppnA[victim]  <= fillPpn;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              fence,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic [PPN_W-1:0]  lkPpn,
  output logic              walkReqValid,
  output logic [VPN_W-1:0]  walkReqVpn,
  input  logic              walkRespValid,
  input  logic [PPN_W-1:0]  walkRespPpn
);
  tlbStrobe_t         strb;
  logic [VPN_W-1:0]   fillVpn;
  logic               walkBusy;
  logic [ENTRIES-1:0] hitVec;

  tlb_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .curAsid(curAsid), .fence(fence),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkHit(lkHit),
    .walkRespValid(walkRespValid), .walkReqValid(walkReqValid),
    .walkReqVpn(walkReqVpn), .fillVpn(fillVpn), .walkBusy(walkBusy),
    .strb(strb)
  );

  tlb_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .curAsid(curAsid),
    .lkValid(lkValid), .lkVpn(lkVpn), .fillVpn(fillVpn), .fillPpn(walkRespPpn),
    .hitVec(hitVec), .lkHit(lkHit), .lkPpn(lkPpn)
  );
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ASID_W-1:0]  curAsid,
  input logic               fence,
  input logic               lkValid,
  input logic               lkHit,
  input logic               walkReqValid,
  input logic               walkBusy,
  input logic               fillStb,
  input logic [ENTRIES-1:0] hitVec
);
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R2

  AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |-> (lkValid && !lkHit)); // R5

  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |=> !walkReqValid); // R6

  AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    fillStb |-> walkBusy); // R6

  AST_FENCE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fence |=> !lkHit); // R3

  AST_ASID_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (curAsid != $past(curAsid)) |=> !walkBusy); // R7
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .rstN(rstN), .curAsid(curAsid), .fence(fence),
  .lkValid(lkValid), .lkHit(lkHit), .walkReqValid(walkReqValid),
  .walkBusy(walkBusy), .fillStb(strb.fill), .hitVec(hitVec)
);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  curAsid = 8'd1;
  logic        fence = 1'b0;
  logic        lkValid = 1'b0;
  logic [19:0] lkVpn = '0;
  logic        lkHit;
  logic [19:0] lkPpn;
  logic        walkReqValid;
  logic [19:0] walkReqVpn;
  logic        walkRespValid = 1'b0;
  logic [19:0] walkRespPpn = '0;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(20), .PPN_W(20), .ASID_W(8)) u0 (
    .clk(clk), .rstN(rstN), .curAsid(curAsid), .fence(fence),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkHit(lkHit), .lkPpn(lkPpn),
    .walkReqValid(walkReqValid), .walkReqVpn(walkReqVpn),
    .walkRespValid(walkRespValid), .walkRespPpn(walkRespPpn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one-cycle lookup, outputs sampled 1 ns after the falling edge
  task automatic lookup(input logic [19:0] vpn, input bit expHit, input logic [19:0] expPpn,
                        input bit expWalk, input string tag);
    @(negedge clk);
    lkValid = 1'b1;
    lkVpn   = vpn;
    #1;
    chk(lkHit == expHit, {tag, " hit"}, 32'(lkHit), 32'(expHit));
    chk(lkPpn == (expHit ? expPpn : 20'h0), {tag, " ppn"}, 32'(lkPpn), 32'(expHit ? expPpn : 20'h0));
    chk(walkReqValid == expWalk, {tag, " walk"}, 32'(walkReqValid), 32'(expWalk));
    if (expWalk)
      chk(walkReqVpn == vpn, {tag, " walkVpn"}, 32'(walkReqVpn), 32'(vpn));
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic respond(input logic [19:0] ppn, input bit withFence);
    @(negedge clk);
    walkRespValid = 1'b1;
    walkRespPpn   = ppn;
    fence         = withFence;
    @(negedge clk);
    walkRespValid = 1'b0;
    fence         = 1'b0;
  endtask

  task automatic setAsid(input logic [7:0] a);
    @(negedge clk);
    curAsid = a;
  endtask

  task automatic fencePulse();
    @(negedge clk);
    fence = 1'b1;
    @(negedge clk);
    fence = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input string tag);
    lookup(vpn, 1'b0, 20'h0, 1'b1, tag);
    respond(ppn, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    chk(walkReqValid == 1'b0 && lkHit == 1'b0, "R1 idle after reset", 32'({lkHit, walkReqValid}), 32'h0);
    lookup(20'h11, 1'b0, 20'h0, 1'b1, "R1 first lookup misses, R5 walk");
    respond(20'h55, 1'b0);
    lookup(20'h11, 1'b1, 20'h55, 1'b0, "R2 refilled entry hits, R5 no walk on hit");
  endtask

  task automatic testBusy();
    lookup(20'h22, 1'b0, 20'h0, 1'b1, "R5 miss starts walk");
    lookup(20'h33, 1'b0, 20'h0, 1'b0, "R6 second miss while busy");
    lookup(20'h11, 1'b1, 20'h55, 1'b0, "R6 hit served while busy");
    respond(20'h66, 1'b0);
    lookup(20'h22, 1'b1, 20'h66, 1'b0, "R6 refill uses recorded vpn");
  endtask

  task automatic testCoexist();
    setAsid(8'd2);
    lookup(20'h11, 1'b0, 20'h0, 1'b1, "R2 other asid misses");
    respond(20'h77, 1'b0);
    lookup(20'h11, 1'b1, 20'h77, 1'b0, "R4 asid 2 page");
    setAsid(8'd1);
    lookup(20'h11, 1'b1, 20'h55, 1'b0, "R4 asid 1 page kept");
  endtask

  task automatic testCancel();
    lookup(20'h44, 1'b0, 20'h0, 1'b1, "R7 walk before change");
    setAsid(8'd3);
    respond(20'h99, 1'b0);
    setAsid(8'd1);
    lookup(20'h44, 1'b0, 20'h0, 1'b1, "R7 late answer dropped");
    respond(20'hAA, 1'b0);
    lookup(20'h44, 1'b1, 20'hAA, 1'b0, "R7 fresh walk fills");
    // identifier change in the same cycle as the answer
    lookup(20'h45, 1'b0, 20'h0, 1'b1, "R7 walk before same-cycle change");
    @(negedge clk);
    curAsid       = 8'd5;
    walkRespValid = 1'b1;
    walkRespPpn   = 20'hEE;
    @(negedge clk);
    walkRespValid = 1'b0;
    setAsid(8'd1);
    lookup(20'h45, 1'b0, 20'h0, 1'b1, "R7 same-cycle answer dropped");
    respond(20'hBB, 1'b0);
    respond(20'hCC, 1'b0);   // stray answer, nothing outstanding
    lookup(20'h45, 1'b1, 20'hBB, 1'b0, "R6 stray answer ignored");
  endtask

  task automatic testFence();
    fencePulse();
    lookup(20'h11, 1'b0, 20'h0, 1'b1, "R3 fence empties array");
    respond(20'h12, 1'b1);   // answer lands in a fence cycle
    lookup(20'h11, 1'b0, 20'h0, 1'b1, "R3 fence-cycle answer dropped");
    respond(20'h13, 1'b0);
    lookup(20'h11, 1'b1, 20'h13, 1'b0, "R3 refill after fence");
  endtask

  task automatic testVictim();
    fencePulse();
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 20'h1000 + 20'(i), "R8 fill");
    for (int i = 0; i < N; i++) lookup(20'h100 + 20'(i), 1'b1, 20'h1000 + 20'(i), 1'b0, "R8 all slots hold");
    fill(20'h200, 20'h2000, "R8 overflow fill");
    lookup(20'h200, 1'b1, 20'h2000, 1'b0, "R8 newest hits");
    lookup(20'h101, 1'b1, 20'h1001, 1'b0, "R8 second oldest kept");
    lookup(20'h100, 1'b0, 20'h0, 1'b1, "R8 oldest evicted");
    respond(20'h3000, 1'b0);
    lookup(20'h101, 1'b0, 20'h0, 1'b1, "R8 next slot evicted");
    respond(20'h3001, 1'b0);
    lookup(20'h102, 1'b0, 20'h0, 1'b1, "R8 third slot evicted");
    respond(20'h3002, 1'b0);
    lookup(20'h100, 1'b1, 20'h3000, 1'b0, "R8 refilled oldest hits");
  endtask

  initial begin
    #(4 * 20000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBusy();
    testCoexist();
    testCancel();
    testFence();
    testVictim();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule